// File: doc/BRIEF.md
# Fractional-Capable 8x8 Multiplier

This unit multiplies two operand bytes and returns a 16-bit product with two condition flags. A three-bit variant select chooses how each operand is read and whether the result is scaled. Each operand can be taken as an unsigned byte or as a two's-complement byte. The scaled forms treat the operands as fixed-point fractions, so the product is doubled. All six variants share one signed 9x9 datapath. Each operand is first widened by one bit, with either its sign or a zero, so a single signed multiply covers the unsigned, signed and mixed cases.

A caller asserts `start` for one cycle with the operands and the select. Two cycles later `done` pulses for one cycle, and the product and flags are valid from then on. The block is fully pipelined: a new start can be given on every cycle, including the cycle in which an earlier result's `done` is high. Results leave in the order the starts arrived. Between results the outputs hold their last values.

The flags follow the conventions for multiply results. Zero reports an all-zero 16-bit result after any scaling. Carry reports the top bit of the unscaled product. No other flag is produced.

Top module: `mulf_unit`

## Requirements
- R1: While `rst_n` is low, `product` is 0, `flag_z` is 0, `flag_c` is 0 and `done` is 0.
- R2: A start sampled at a clock edge makes `done` high for exactly one cycle, starting after the next edge (the cycle two after the start cycle); starts on consecutive cycles give results in consecutive cycles, in order.
- R3: While `done` is low, `product`, `flag_z` and `flag_c` keep their previous values.
- R4: Select `3'b000` multiplies both operands as unsigned values 0..255.
- R5: Select `3'b001` multiplies both operands as signed values -128..127.
- R6: Select `3'b010` multiplies `opa` as a signed value by `opb` as an unsigned value.
- R7: When select bit 2 is 1, the result is the integer product of the variant given by bits 1:0, shifted left by one and truncated to 16 bits; for example, `3'b101` with 0x80 x 0x80 gives 0x8000.
- R8: `flag_z` is 1 exactly when the 16-bit result, after any shift, is zero.
- R9: `flag_c` equals bit 15 of the 16-bit product before the fractional shift.
- R10: Select bits 1:0 equal to `2'b11` behave as the unsigned variant.
- R11: Operand and select values present while `start` is low have no effect: no `done` follows, and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the operands and select this cycle |
| mode | input | 3 | Bit 2 selects the fractional shift; bits 1:0 select signedness (00 unsigned, 01 signed, 10 signed x unsigned, 11 unsigned) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| product | output | 16 | Result of the most recent completed multiply |
| flag_z | output | 1 | Zero flag of the most recent result |
| flag_c | output | 1 | Carry flag of the most recent result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Operand patterns with the top bit set in one or both bytes (0xFF, 0x80) separate the three ways of widening operands. The same byte pair gives a different product under the unsigned, signed and mixed selects, so a wrong sign extension shows up at once. Pairs whose product has bit 15 set, or whose shifted result loses that bit, check that carry is taken before the shift and zero after it. The 0x80 x 0x80 fractional case checks truncation. Random operands are mixed with idle cycles that carry random data, and with back-to-back starts. These check that the pipeline keeps results in order and that data present while `start` is low leaves no trace.

// File: rtl/mulf_pkg.sv
package mulf_pkg;

   // signedness selected by mode[1:0]
   typedef enum logic [1:0] {
      SIGN_UU  = 2'b00,
      SIGN_SS  = 2'b01,
      SIGN_SU  = 2'b10,
      SIGN_RSV = 2'b11
   } mulf_sign_e;

   localparam int MODE_W = 3;

   function automatic logic first_is_signed(input mulf_sign_e k);
      return (k == SIGN_SS) || (k == SIGN_SU);
   endfunction

   function automatic logic second_is_signed(input mulf_sign_e k);
      return (k == SIGN_SS);
   endfunction

endpackage

// File: rtl/mulf_operand_stage.sv
module mulf_operand_stage
   import mulf_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [MODE_W-1:0]        mode,
   input  logic [DATA_W-1:0]        opa,
   input  logic [DATA_W-1:0]        opb,
   output logic                     s1_valid,
   output logic                     s1_frac,
   output mulf_sign_e               s1_kind,
   output logic signed [DATA_W:0]   s1_xa,
   output logic signed [DATA_W:0]   s1_xb
);

   mulf_sign_e           kind_in;
   logic signed [DATA_W:0] xa_in, xb_in;

   always_comb begin
      kind_in = mulf_sign_e'(mode[1:0]);
      xa_in   = {first_is_signed(kind_in)  & opa[DATA_W-1], opa};
      xb_in   = {second_is_signed(kind_in) & opb[DATA_W-1], opb};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_frac  <= 1'b0;
         s1_kind  <= SIGN_UU;
         s1_xa    <= '0;
         s1_xb    <= '0;
      end else begin
         s1_valid <= start;
         if (start) begin
            s1_frac <= mode[2];
            s1_kind <= kind_in;
            s1_xa   <= xa_in;
            s1_xb   <= xb_in;
         end
      end
   end

endmodule

// File: rtl/mulf_core.sv
module mulf_core #(
   parameter int DATA_W     = 8,
   parameter int ARRAY_IMPL = 0,
   localparam int FULL_W    = 2*DATA_W + 2
) (
   input  logic signed [DATA_W:0]   xa,
   input  logic signed [DATA_W:0]   xb,
   output logic signed [FULL_W-1:0] full
);

   logic signed [FULL_W-1:0] ea;
   assign ea = FULL_W'(xa);

   generate
      if (ARRAY_IMPL == 0) begin : g_behav
         logic signed [FULL_W-1:0] eb;
         assign eb   = FULL_W'(xb);
         assign full = ea * eb;
      end else begin : g_array
         // shift-add rows; the top row of a two's complement multiplier subtracts
         logic signed [FULL_W-1:0] acc [0:DATA_W+1];
         assign acc[0] = '0;
         for (genvar i = 0; i <= DATA_W; i++) begin : g_row
            logic signed [FULL_W-1:0] pp;
            assign pp = xb[i] ? (ea <<< i) : '0;
            if (i < DATA_W) begin : g_add
               assign acc[i+1] = acc[i] + pp;
            end else begin : g_sub
               assign acc[i+1] = acc[i] - pp;
            end
         end
         assign full = acc[DATA_W+1];
      end
   endgenerate

endmodule

// File: rtl/mulf_result_stage.sv
module mulf_result_stage #(
   parameter int DATA_W  = 8,
   localparam int PROD_W = 2*DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_frac,
   input  logic [PROD_W-1:0] raw,
   output logic [PROD_W-1:0] product,
   output logic              flag_z,
   output logic              flag_c,
   output logic              done
);

   logic [PROD_W-1:0] scaled;
   assign scaled = in_frac ? {raw[PROD_W-2:0], 1'b0} : raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         product <= '0;
         flag_z  <= 1'b0;
         flag_c  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= in_valid;
         if (in_valid) begin
            product <= scaled;
            flag_z  <= (scaled == '0);
            flag_c  <= raw[PROD_W-1];
         end
      end
   end

endmodule

// File: rtl/mulf_unit.sv
module mulf_unit
   import mulf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ARRAY_IMPL = 0,
   localparam int PROD_W    = 2*DATA_W,
   localparam int FULL_W    = 2*DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        mode,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [PROD_W-1:0] product,
   output logic              flag_z,
   output logic              flag_c,
   output logic              done
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mulf_unit: DATA_W must be at least 2");
      end
      if (ARRAY_IMPL != 0 && ARRAY_IMPL != 1) begin : g_bad_impl
         $error("mulf_unit: ARRAY_IMPL must be 0 or 1");
      end
   endgenerate

   logic                     s1_valid;
   logic                     s1_frac;
   mulf_sign_e               s1_kind;
   logic signed [DATA_W:0]   s1_xa, s1_xb;
   logic signed [FULL_W-1:0] full;

   mulf_operand_stage #(.DATA_W(DATA_W)) u_ops (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .opa(opa), .opb(opb),
      .s1_valid(s1_valid), .s1_frac(s1_frac), .s1_kind(s1_kind),
      .s1_xa(s1_xa), .s1_xb(s1_xb)
   );

   mulf_core #(.DATA_W(DATA_W), .ARRAY_IMPL(ARRAY_IMPL)) u_core (
      .xa(s1_xa), .xb(s1_xb), .full(full)
   );

   mulf_result_stage #(.DATA_W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_frac(s1_frac),
      .raw(full[PROD_W-1:0]),
      .product(product), .flag_z(flag_z), .flag_c(flag_c), .done(done)
   );

   // R2
   start_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> ##2 done);

   // R2
   done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start, 2));

   // R3
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(product) && $stable(flag_z) && $stable(flag_c)));

   // R4
   unsigned_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && (s1_kind == SIGN_UU || s1_kind == SIGN_RSV)) |-> (full >= 0));

   // R5
   signed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_kind == SIGN_SS && s1_xa != 0 && s1_xb != 0)
         |-> ((full < 0) == (s1_xa[DATA_W] ^ s1_xb[DATA_W])));

   // R8
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flag_z == (product == '0)));

endmodule

// File: tb/mulf_unit_tb.sv
`timescale 1ns/1ps
module mulf_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [7:0]  opa = '0, opb = '0;
   logic [15:0] product;
   logic        flag_z, flag_c, done;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mulf_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .opa(opa), .opb(opb),
      .product(product), .flag_z(flag_z), .flag_c(flag_c), .done(done)
   );

   // history of stimuli: h1 driven one negedge ago, h2 two ago
   logic       h1_s = 0, h2_s = 0;
   logic [2:0] h1_m = 0, h2_m = 0;
   logic [7:0] h1_a = 0, h2_a = 0, h1_b = 0, h2_b = 0;
   logic [15:0] held_p = 0;
   logic        held_z = 0, held_c = 0;

   // returns {carry, zero, result}
   function automatic logic [17:0] model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
      int ia, ib, p;
      logic [15:0] raw, res;
      ia = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
      ib = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
      p = ia * ib;
      raw = p[15:0];
      res = m[2] ? {raw[14:0], 1'b0} : raw;
      return {raw[15], (res == 16'h0), res};
   endfunction

   function automatic string req_of(input logic [2:0] m);
      if (m[2]) return "R7";
      case (m[1:0])
         2'b01:   return "R5";
         2'b10:   return "R6";
         2'b11:   return "R10";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (mode=%b a=%h b=%h)", req, act, exp, h2_m, h2_a, h2_b);
      end
   endtask

   task automatic step(input logic s, input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
      logic [17:0] e;
      @(negedge clk);
      if (h2_s) begin
         e = model(h2_m, h2_a, h2_b);
         chk("R2", {31'b0, done}, 32'd1);
         chk(req_of(h2_m), {16'b0, product}, {16'b0, e[15:0]});
         chk("R8", {31'b0, flag_z}, {31'b0, e[16]});
         chk("R9", {31'b0, flag_c}, {31'b0, e[17]});
         held_p = e[15:0]; held_z = e[16]; held_c = e[17];
      end else begin
         // R3 and R11: idle data leaves no trace
         chk("R11", {31'b0, done}, 32'd0);
         chk("R3", {13'b0, flag_c, flag_z, product}, {13'b0, held_c, held_z, held_p});
      end
      h2_s = h1_s; h2_m = h1_m; h2_a = h1_a; h2_b = h1_b;
      h1_s = s;    h1_m = m;    h1_a = a;    h1_b = b;
      start = s; mode = m; opa = a; opb = b;
   endtask

   initial begin
      #(10 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", {13'b0, flag_c, flag_z, done, product}, 32'd0);
      start = 1; mode = 3'b001; opa = 8'hFF; opb = 8'hFF;
      @(negedge clk);
      chk("R1", {13'b0, flag_c, flag_z, done, product}, 32'd0);
      start = 0;
      rst_n = 1'b1;

      // directed corners
      step(1, 3'b000, 8'hFF, 8'hFF);  // R4 0xFE01, carry set
      step(1, 3'b001, 8'hFF, 8'hFF);  // R5 -1 x -1
      step(1, 3'b010, 8'hFF, 8'hFF);  // R6 -1 x 255
      step(1, 3'b011, 8'hFF, 8'hFF);  // R10 as unsigned
      step(1, 3'b101, 8'h80, 8'h80);  // R7 -> 0x8000
      step(1, 3'b100, 8'hFF, 8'h81);  // R9 carry before shift
      step(1, 3'b001, 8'h00, 8'h80);  // R8 zero
      step(1, 3'b110, 8'h80, 8'hFF);  // R6/R7 mixed fractional
      step(1, 3'b001, 8'h80, 8'h7F);  // R5 negative
      step(0, 3'b000, 8'h12, 8'h34);  // R11 idle with data
      step(0, 3'b101, 8'hAA, 8'h55);
      step(0, 3'b000, 8'h00, 8'h00);
      step(1, 3'b111, 8'h40, 8'h40);
      step(1, 3'b100, 8'h00, 8'h00);

      for (int i = 0; i < 600; i++) begin
         logic s;
         s = ($urandom % 10) < 7;
         step(s, 3'($urandom), 8'($urandom), 8'($urandom));
      end
      step(0, 3'b000, 8'h00, 8'h00);
      step(0, 3'b000, 8'h00, 8'h00);
      step(0, 3'b000, 8'h00, 8'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule